// File: doc/BRIEF.md
# Reset configuration word fetcher

After a hard reset this block reads a table of configuration bytes from boot memory over a simple byte-read bus. It issues 32 single-byte reads, one at a time, on a 64-bit address stride. It takes each byte from one fixed lane of the data bus, so the port width of the boot device has no effect. Every four bytes form one 32-bit word.

The first word is the block's own configuration word. The remaining seven words are held, each with a valid flag, for subordinate devices. One bit of the own word selects the exception base, and the block presents the resulting reset vector address. When the last byte has been captured, the block raises a one-cycle completion pulse and a sticky done flag.

Top module: `cfg_word_fetch`

## Requirements
- R1: While reset is asserted, rd_addr is 0, rd_req is 1, done and done_pulse are 0, sub_valid is all zeros, and own_word and sub_words read as zero.
- R2: Only one read is outstanding at a time. While rd_req is high and rd_ack is low, rd_addr holds its value.
- R3: The read addresses run 0, 8, 16, ... 248, so there are exactly 32 reads. Each address advances only after the cycle in which rd_ack is sampled high. After the 32nd acknowledge, rd_req stays low.
- R4: The captured byte is rd_data[63:56]. Bits 55:0 of rd_data have no effect on any output.
- R5: Reads 4k to 4k+3 form word k. The first of the four bytes becomes bits 31:24 of the word and the fourth becomes bits 7:0. A word appears on its output in the cycle after its fourth byte is acknowledged.
- R6: Word 0 drives own_word. Word k, for k = 1 to 7, drives sub_words[32k-1:32k-32].
- R7: sub_valid[k-1] rises in the cycle after the fourth byte of word k is acknowledged, and stays high until reset.
- R8: Bit 28 of own_word selects the reset vector. A value of 0 gives 0x00000100 and a value of 1 gives 0xFFF00100.
- R9: done_pulse is high for exactly the one cycle after the 32nd byte is acknowledged. done rises in that same cycle and stays high until reset.
- R10: Reset asserted in the middle of a fetch restarts the sequence at address 0 and clears done, the valid flags and the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | output | 32 | Byte address of the current read |
| rd_req | output | 1 | Read request for rd_addr |
| rd_data | input | 64 | Read data bus; only the top lane is used |
| rd_ack | input | 1 | The read completes in a cycle where this is high together with rd_req |
| own_word | output | 32 | The block's own assembled configuration word |
| rst_vector | output | 32 | Reset vector address decoded from own_word |
| sub_words | output | 224 | Words for subordinates 1 to 7, with subordinate 1 in the low bits |
| sub_valid | output | 7 | Per-subordinate word valid flag |
| done_pulse | output | 1 | One-cycle pulse when the fetch completes |
| done | output | 1 | Sticky fetch-complete flag |

## Verification
The case hardest to reach from the ports is a reset that lands in the middle of a word, after some bytes have already gone into the assembly register. The stimulus reaches it by applying reset partway through a run with irregular acknowledge timing. The following full run must then rebuild every word from byte zero, with no residue from the interrupted run. The irregular acknowledges also hold addresses across stall cycles. All of the low 56 data bits carry changing junk, so any capture from the wrong lane changes a word.

// File: rtl/cfg_fetch_pkg.sv
package cfg_fetch_pkg;

   typedef enum logic {
      PH_FETCH  = 1'b0,
      PH_FINISH = 1'b1
   } fetch_phase_t;

   localparam int unsigned CFG_BYTE_W = 8;

   function automatic logic [31:0] pick_vector(input logic prefix,
                                               input logic [31:0] hi_base,
                                               input logic [31:0] offset);
      return (prefix ? hi_base : 32'h0000_0000) + offset;
   endfunction

endpackage

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
   import cfg_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned TOTAL  = 32,
   parameter int unsigned STRIDE = 8,
   localparam int unsigned IDX_W = $clog2(TOTAL),
   localparam int unsigned SHIFT = $clog2(STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ack,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              cap_en,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              done_pulse,
   output logic              done
);

   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(TOTAL - 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((TOTAL - 1) * STRIDE);

   generate
      if ((1 << SHIFT) != STRIDE) begin : g_bad_stride
         $error("STRIDE must be a power of two");
      end
      if ((1 << IDX_W) != TOTAL) begin : g_bad_total
         $error("TOTAL must be a power of two");
      end
   endgenerate

   fetch_phase_t phase;
   logic [IDX_W-1:0] idx;
   logic pulse_q;

   assign rd_req     = (phase == PH_FETCH);
   assign cap_en     = rd_req & rd_ack;
   assign cap_idx    = idx;
   assign rd_addr    = ADDR_W'(idx) << SHIFT;
   assign done       = (phase == PH_FINISH);
   assign done_pulse = pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_FETCH;
         idx     <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (cap_en) begin
            if (idx == LAST_IDX) begin
               phase   <= PH_FINISH;
               pulse_q <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   // R2: a stalled read keeps its address
   a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> $stable(rd_addr));

   // R3: each accepted read moves the address by one stride
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ack && rd_addr != LAST_ADDR) |=>
         (rd_addr == $past(rd_addr) + ADDR_W'(STRIDE)));

   // R9: completion pulse lasts a single cycle
   a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   // R9: done is sticky
   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R9: the pulse follows the final acknowledge
   a_r9_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> done_pulse);

endmodule

// File: rtl/cfg_lane_pick.sv
module cfg_lane_pick
   import cfg_fetch_pkg::*;
#(
   parameter int unsigned BUS_W    = 64,
   parameter bit          LANE_TOP = 1'b1
) (
   input  logic [BUS_W-1:0]      bus,
   output logic [CFG_BYTE_W-1:0] lane
);

   logic lane_unused;

   generate
      if (BUS_W < 2 * CFG_BYTE_W || (BUS_W % CFG_BYTE_W) != 0) begin : g_bad_bus
         $error("BUS_W must be a multiple of the byte width and at least two bytes");
      end
      if (LANE_TOP) begin : g_top
         assign lane        = bus[BUS_W-1 -: CFG_BYTE_W];
         assign lane_unused = ^bus[BUS_W-CFG_BYTE_W-1:0];
      end else begin : g_bottom
         assign lane        = bus[CFG_BYTE_W-1:0];
         assign lane_unused = ^bus[BUS_W-1:CFG_BYTE_W];
      end
   endgenerate

endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm
   import cfg_fetch_pkg::*;
#(
   parameter int unsigned N_WORDS = 8,
   parameter int unsigned BPW     = 4,
   localparam int unsigned WORD_W = BPW * CFG_BYTE_W,
   localparam int unsigned ACC_W  = WORD_W - CFG_BYTE_W,
   localparam int unsigned POS_W  = $clog2(BPW),
   localparam int unsigned SLOT_W = $clog2(N_WORDS),
   localparam int unsigned IDX_W  = POS_W + SLOT_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [IDX_W-1:0]          cap_idx,
   input  logic [CFG_BYTE_W-1:0]     byte_in,
   output logic [N_WORDS*WORD_W-1:0] words,
   output logic [N_WORDS-2:0]        valid
);

   generate
      if (BPW < 2 || (1 << POS_W) != BPW) begin : g_bad_bpw
         $error("BPW must be a power of two and at least 2");
      end
      if (N_WORDS < 2 || (1 << SLOT_W) != N_WORDS) begin : g_bad_words
         $error("N_WORDS must be a power of two and at least 2");
      end
   endgenerate

   logic [ACC_W-1:0]  acc;
   logic [SLOT_W-1:0] slot;
   logic              word_end;

   assign slot     = cap_idx[IDX_W-1:POS_W];
   assign word_end = cap_en && (cap_idx[POS_W-1:0] == POS_W'(BPW - 1));

   generate
      if (ACC_W == CFG_BYTE_W) begin : g_acc_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc <= '0;
            else if (cap_en) acc <= byte_in;
         end
      end else begin : g_acc_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc <= '0;
            else if (cap_en) acc <= {acc[ACC_W-CFG_BYTE_W-1:0], byte_in};
         end
      end

      for (genvar w = 0; w < N_WORDS; w++) begin : g_slot
         logic [WORD_W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held <= '0;
            else if (word_end && slot == SLOT_W'(w))
               held <= {acc, byte_in};
         end
         assign words[w*WORD_W +: WORD_W] = held;

         if (w > 0) begin : g_flag
            logic flag;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  flag <= 1'b0;
               else if (word_end && slot == SLOT_W'(w))
                  flag <= 1'b1;
            end
            assign valid[w-1] = flag;
         end
      end
   endgenerate

   // R7: a valid flag never falls outside reset
   a_r7_valid_keep: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((valid & $past(valid)) == $past(valid)));

   // R7: at most one flag rises per cycle
   a_r7_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $onehot0(valid & ~$past(valid)));

endmodule

// File: rtl/cfg_vec_decode.sv
module cfg_vec_decode
   import cfg_fetch_pkg::*;
#(
   parameter int unsigned PREFIX_POS = 28,
   parameter logic [31:0] HI_BASE    = 32'hFFF0_0000,
   parameter logic [31:0] VEC_OFF    = 32'h0000_0100
) (
   input  logic [31:0] own_word,
   output logic [31:0] rst_vector
);

   generate
      if (PREFIX_POS > 31) begin : g_bad_pos
         $error("PREFIX_POS must lie inside the word");
      end
   endgenerate

   assign rst_vector = pick_vector(own_word[PREFIX_POS], HI_BASE, VEC_OFF);

endmodule

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch
   import cfg_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned BUS_W      = 64,
   parameter int unsigned STRIDE     = 8,
   parameter int unsigned N_WORDS    = 8,
   parameter int unsigned BPW        = 4,
   parameter bit          LANE_TOP   = 1'b1,
   parameter int unsigned PREFIX_POS = 28,
   parameter logic [31:0] HI_BASE    = 32'hFFF0_0000,
   parameter logic [31:0] VEC_OFF    = 32'h0000_0100,
   localparam int unsigned WORD_W    = BPW * CFG_BYTE_W,
   localparam int unsigned TOTAL     = N_WORDS * BPW,
   localparam int unsigned IDX_W     = $clog2(TOTAL)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic [ADDR_W-1:0]             rd_addr,
   output logic                          rd_req,
   input  logic [BUS_W-1:0]              rd_data,
   input  logic                          rd_ack,
   output logic [WORD_W-1:0]             own_word,
   output logic [31:0]                   rst_vector,
   output logic [(N_WORDS-1)*WORD_W-1:0] sub_words,
   output logic [N_WORDS-2:0]            sub_valid,
   output logic                          done_pulse,
   output logic                          done
);

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("the own word must be 32 bits wide for vector decode");
      end
   endgenerate

   logic                      cap_en;
   logic [IDX_W-1:0]          cap_idx;
   logic [CFG_BYTE_W-1:0]     lane_byte;
   logic [N_WORDS*WORD_W-1:0] all_words;

   cfg_fetch_seq #(
      .ADDR_W (ADDR_W),
      .TOTAL  (TOTAL),
      .STRIDE (STRIDE)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_ack     (rd_ack),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .done_pulse (done_pulse),
      .done       (done)
   );

   cfg_lane_pick #(
      .BUS_W    (BUS_W),
      .LANE_TOP (LANE_TOP)
   ) lane_i (
      .bus  (rd_data),
      .lane (lane_byte)
   );

   cfg_word_asm #(
      .N_WORDS (N_WORDS),
      .BPW     (BPW)
   ) asm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .cap_idx (cap_idx),
      .byte_in (lane_byte),
      .words   (all_words),
      .valid   (sub_valid)
   );

   assign own_word  = all_words[WORD_W-1:0];
   assign sub_words = all_words[N_WORDS*WORD_W-1:WORD_W];

   cfg_vec_decode #(
      .PREFIX_POS (PREFIX_POS),
      .HI_BASE    (HI_BASE),
      .VEC_OFF    (VEC_OFF)
   ) vec_i (
      .own_word   (own_word),
      .rst_vector (rst_vector)
   );

   // R9 R7: once done, every subordinate word is valid
   a_r9_all_valid_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sub_valid == '1));

endmodule

// File: tb/cfg_word_fetch_tb_top.sv
module cfg_word_fetch_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  rd_addr;
   logic         rd_req;
   logic [63:0]  rd_data = '0;
   logic         rd_ack = 1'b0;
   logic [31:0]  own_word;
   logic [31:0]  rst_vector;
   logic [223:0] sub_words;
   logic [6:0]   sub_valid;
   logic         done_pulse;
   logic         done;

   always #2 clk = ~clk;

   cfg_word_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_req(rd_req),
      .rd_data(rd_data), .rd_ack(rd_ack), .own_word(own_word),
      .rst_vector(rst_vector), .sub_words(sub_words), .sub_valid(sub_valid),
      .done_pulse(done_pulse), .done(done)
   );

   int checks = 0;
   int fails = 0;
   logic [7:0]  mem [32];
   int          ack_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [55:0] junk = 56'h5A5A_1234_C3C3_9F;

   // behavioural reference model
   int          idx_m = 0;
   bit          done_m = 0, pulse_m = 0;
   logic [6:0]  valid_m = '0;
   logic [31:0] words_m [8];

   task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                      input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         idx_m = 0; done_m = 0; pulse_m = 0; valid_m = '0;
         for (int k = 0; k < 8; k++) words_m[k] = '0;
      end else begin
         pulse_m = 0;
         if (!done_m && rd_ack) begin
            if (idx_m % 4 == 3) begin
               words_m[idx_m/4] = {mem[idx_m-3], mem[idx_m-2], mem[idx_m-1], mem[idx_m]};
               if (idx_m / 4 > 0) valid_m[idx_m/4-1] = 1'b1;
            end
            if (idx_m == 31) begin done_m = 1; pulse_m = 1; end
            else idx_m++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [223:0] sub_e;
         for (int j = 0; j < 7; j++) sub_e[32*j +: 32] = words_m[j+1];
         chk(rd_addr == 32'(idx_m * 8), "R3 rd_addr", 256'(rd_addr), 256'(idx_m * 8));
         chk(rd_req == !done_m, "R2 rd_req", 256'(rd_req), 256'(!done_m));
         chk(done == done_m, "R9 done", 256'(done), 256'(done_m));
         chk(done_pulse == pulse_m, "R9 done_pulse", 256'(done_pulse), 256'(pulse_m));
         chk(sub_valid == valid_m, "R7 sub_valid", 256'(sub_valid), 256'(valid_m));
         // R5 and R4: words built from the top lane only, junk elsewhere
         chk(own_word == words_m[0], "R5 own_word", 256'(own_word), 256'(words_m[0]));
         chk(sub_words == sub_e, "R6 sub_words", 256'(sub_words), 256'(sub_e));
         chk(rst_vector == (words_m[0][28] ? 32'hFFF0_0100 : 32'h0000_0100),
             "R8 rst_vector", 256'(rst_vector),
             256'(words_m[0][28] ? 32'hFFF0_0100 : 32'h0000_0100));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      junk = {junk[54:0], junk[55] ^ junk[30]};
      rd_ack = (ack_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      rd_data = {(rd_addr < 256) ? mem[rd_addr/8] : 8'h00, junk};
   end

   task automatic fill_mem(input logic [31:0] own, input int seed);
      for (int i = 0; i < 32; i++) mem[i] = 8'((i * 37 + seed) & 255);
      mem[0] = own[31:24]; mem[1] = own[23:16]; mem[2] = own[15:8]; mem[3] = own[7:0];
   endtask

   task automatic reset_check(input string tag);
      @(posedge clk); #1 rst_n = 1'b0;
      @(negedge clk);
      chk(rd_addr == 0 && rd_req && !done && !done_pulse && sub_valid == 0 &&
          own_word == 0 && sub_words == 0,
          tag, 256'({rd_addr, rd_req, done, done_pulse, sub_valid}), 256'(32'h0 << 10 | 1 << 9));
      @(posedge clk); #1 rst_n = 1'b1;
   endtask

   task automatic run_to_done(input int limit);
      int n = 0;
      while (!done && n < limit) begin @(negedge clk); n++; end
      if (!done) begin
         fails++; checks++;
         $display("FAIL R3 watchdog actual=not_done expected=done");
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      // run A: ack every cycle, prefix bit clear
      fill_mem(32'h0123_4567, 11);
      ack_mode = 0;
      reset_check("R1 reset state");
      run_to_done(2000);

      // run B: irregular acks, reset mid-word, prefix bit set
      fill_mem(32'hF00D_BEEF, 91);
      ack_mode = 1;
      reset_check("R1 reset state before run B");
      repeat (23) @(negedge clk);
      reset_check("R10 reset mid fetch");
      run_to_done(4000);

      // run C: different data, irregular acks
      fill_mem(32'h1FFF_FFFF, 200);
      reset_check("R10 reset after done");
      run_to_done(4000);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule